// File: doc/BRIEF.md
# I2C Digital Potentiometer Register Interface

This block is the digital front end of a single-channel digital potentiometer. It acts as an I2C slave on a two-wire bus. SCL and SDA are oversampled by the system clock. The slave pulls SDA low through an open-drain style enable and otherwise leaves the line free. It holds two volatile 8-bit registers. The first is the wiper code that selects a tap of the resistor string. The second is a control register whose one live bit selects normal operation or shutdown.

The 7-bit device address has a fixed upper part set by a parameter and a lower two bits taken from strap inputs, so four of these blocks can share one bus. A host writes a register with a frame of address byte, register-pointer byte and data byte. It reads a register by writing the pointer, issuing a repeated START and reading one byte. A supply-glitch input returns the wiper code to mid-scale, but only while the device is in shutdown.

Top module: `dpot_i2c_regs`

## Requirements
- R1: The device address is {ADDR_HI, strap_i}, with the default ADDR_HI = 5'b01011 forming bits 6..2 and strap_i forming bits 1..0. A matching address byte (R/W in bit 0) is acknowledged by driving SDA low during the ninth clock.
- R2: An address byte that does not match is not acknowledged, changes no register, and the slave keeps SDA released until the next START.
- R3: The wiper register sits at register address 00h. It is written by a write frame and read back by a pointer write, a repeated START and a one-byte read, for any code from 00h to FFh. wiper_o always shows the stored code.
- R4: After reset wiper_o is 80h, shutdown_o is 0, the wiper register reads 80h and the control register reads 40h.
- R5: The control register sits at register address 10h. Only bit 6 is stored, and the other bits read as 0. Bit 6 written 0 sets shutdown_o to 1, and bit 6 written 1 sets shutdown_o to 0. shutdown_o changes by no other means.
- R6: Entering or leaving shutdown leaves the wiper register and wiper_o unchanged.
- R7: While shutdown_o is 1, brownout_i high loads 80h into the wiper register on the next clock. While shutdown_o is 0, brownout_i has no effect.
- R8: Register addresses other than 00h and 10h are acknowledged. Writes to them change nothing, and reads from them return 00h.
- R9: More data bytes after the first in one write frame are each acknowledged and written to the same register, so the last one is kept.
- R10: The slave changes its SDA drive only while SCL is low, so it never produces a false START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| strap_i | input | 2 | Low two bits of the device address |
| brownout_i | input | 1 | Supply-glitch indication |
| wiper_o | output | 8 | Current wiper tap code |
| shutdown_o | output | 1 | High while the potentiometer is in shutdown |

## Verification
The assertions assume that the bus master holds SCL low for several system clocks after each falling edge, so the slave's registered SDA change lands while the synchronised clock is still low. They also assume that brownout_i is synchronous to clk. The bench uses a quarter bit time of eight clocks and changes its own SDA only in the middle of the SCL low phase. It drives brownout_i on falling clock edges. A bench monitor also flags any change of the slave's SDA drive while the SCL pin is high.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int BYTE_W   = 8;
    localparam int DEV_AW   = 7;
    localparam int BIT_CW   = 4;

    localparam logic [BYTE_W-1:0] REG_WIPER  = 8'h00;
    localparam logic [BYTE_W-1:0] REG_CTRL   = 8'h10;
    localparam logic [BYTE_W-1:0] WIPER_MID  = 8'h80;
    localparam int                CTRL_RUN_BIT = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } bus_state_e;

    typedef struct packed {
        bus_state_e         st;
        logic [BIT_CW-1:0]  cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  ptr;
        logic               rw;
        logic               sel;
        logic               sda_oe;
        logic               wr_en;
        logic [BYTE_W-1:0]  wr_data;
    } fsm_t;

    typedef struct packed {
        logic [BYTE_W-1:0]  wiper;
        logic               run;
    } regs_t;

endpackage

// File: rtl/dpot_bus_filter.sv
module dpot_bus_filter #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0]             raw;
    logic [LINES-1:0][STAGES-1:0] pipe_d, pipe_q;
    logic                         scl_p_d, scl_p_q, sda_p_d, sda_p_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign pipe_d[g] = {pipe_q[g][STAGES-2:0], raw[g]};
    end

    always_comb begin
        scl_s   = pipe_q[0][STAGES-1];
        sda_s   = pipe_q[1][STAGES-1];
        scl_p_d = scl_s;
        sda_p_d = sda_s;
        scl_rise  = scl_s & ~scl_p_q;
        scl_fall  = ~scl_s & scl_p_q;
        start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
        stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q  <= '1;
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            pipe_q  <= pipe_d;
            scl_p_q <= scl_p_d;
            sda_p_q <= sda_p_d;
        end
    end

endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              brownout,
    output logic [BYTE_W-1:0] wiper,
    output logic              run
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == REG_WIPER) r_d.wiper = wr_data;
            if (wr_addr == REG_CTRL)  r_d.run   = wr_data[CTRL_RUN_BIT];
        end
        if (brownout && !r_q.run) r_d.wiper = WIPER_MID;

        rd_data = '0;
        if (rd_addr == REG_WIPER) rd_data = r_q.wiper;
        if (rd_addr == REG_CTRL)  rd_data[CTRL_RUN_BIT] = r_q.run;

        wiper = r_q.wiper;
        run   = r_q.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.wiper <= WIPER_MID;
            r_q.run   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/dpot_bus_fsm.sv
module dpot_bus_fsm
    import dpot_pkg::*;
#(
    parameter int                        STRAP_W = 2,
    parameter logic [DEV_AW-STRAP_W-1:0] ADDR_HI = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               wr_en,
    output logic [BYTE_W-1:0]  wr_data,
    output logic [BYTE_W-1:0]  ptr,
    output logic               sel
);
    localparam logic [BIT_CW-1:0] BITS_PER_BYTE = BIT_CW'(BYTE_W);

    fsm_t q, n;
    logic [DEV_AW-1:0] my_addr;

    assign my_addr = {ADDR_HI, strap};

    always_comb begin
        n       = q;
        n.wr_en = 1'b0;
        if (start_det) begin
            n.st     = ST_ADDR;
            n.cnt    = '0;
            n.sda_oe = 1'b0;
            n.sel    = 1'b0;
        end else if (stop_det) begin
            n.st     = ST_IDLE;
            n.sda_oe = 1'b0;
            n.sel    = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise && q.cnt < BITS_PER_BYTE) begin
                        n.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        n.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS_PER_BYTE) begin
                        n.cnt = '0;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[BYTE_W-1:1] == my_addr) begin
                                n.st     = ST_ADDR_ACK;
                                n.sda_oe = 1'b1;
                                n.sel    = 1'b1;
                                n.rw     = q.sh[0];
                            end else begin
                                n.st = ST_SKIP;
                            end
                        end else if (q.st == ST_REG) begin
                            n.st     = ST_REG_ACK;
                            n.sda_oe = 1'b1;
                            n.ptr    = q.sh;
                        end else begin
                            n.st      = ST_WDATA_ACK;
                            n.sda_oe  = 1'b1;
                            n.wr_en   = 1'b1;
                            n.wr_data = q.sh;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.rw) begin
                            n.st     = ST_RDATA;
                            n.sh     = rd_data;
                            n.sda_oe = ~rd_data[BYTE_W-1];
                        end else begin
                            n.st     = ST_REG;
                            n.sda_oe = 1'b0;
                        end
                    end
                end
                ST_REG_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        n.st     = ST_WDATA;
                        n.cnt    = '0;
                        n.sda_oe = 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && q.cnt < BITS_PER_BYTE) begin
                        n.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == BITS_PER_BYTE) begin
                            n.st     = ST_RDATA_ACK;
                            n.sda_oe = 1'b0;
                        end else begin
                            n.sh     = {q.sh[BYTE_W-2:0], 1'b0};
                            n.sda_oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_fall) n.st = ST_SKIP;
                end
                default: begin
                    n.sda_oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.cnt     <= '0;
            q.sh      <= '0;
            q.ptr     <= '0;
            q.rw      <= 1'b0;
            q.sel     <= 1'b0;
            q.sda_oe  <= 1'b0;
            q.wr_en   <= 1'b0;
            q.wr_data <= '0;
        end else begin
            q <= n;
        end
    end

    assign sda_oe  = q.sda_oe;
    assign wr_en   = q.wr_en;
    assign wr_data = q.wr_data;
    assign ptr     = q.ptr;
    assign sel     = q.sel;

endmodule

// File: rtl/dpot_i2c_regs.sv
module dpot_i2c_regs
    import dpot_pkg::*;
#(
    parameter int                        SYNC_STAGES = 2,
    parameter int                        STRAP_W     = 2,
    parameter logic [DEV_AW-STRAP_W-1:0] ADDR_HI     = 5'b01011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               brownout_i,
    output logic [BYTE_W-1:0]  wiper_o,
    output logic               shutdown_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              reg_wr_en, bus_sel, run;
    logic [BYTE_W-1:0] reg_wr_data, reg_ptr, reg_rd_data;

    dpot_bus_filter #(.STAGES(SYNC_STAGES)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dpot_bus_fsm #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (reg_rd_data),
        .sda_oe    (sda_oe_o),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .ptr       (reg_ptr),
        .sel       (bus_sel)
    );

    dpot_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_ptr),
        .wr_data  (reg_wr_data),
        .rd_addr  (reg_ptr),
        .rd_data  (reg_rd_data),
        .brownout (brownout_i),
        .wiper    (wiper_o),
        .run      (run)
    );

    assign shutdown_o = ~run;

endmodule

// File: rtl/dpot_i2c_chk.sv
module dpot_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       sel,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic       brownout,
    input logic       shutdown,
    input logic [7:0] wiper
);
    assert_write_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sel);

    assert_ctrl_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 8'h10) |=> $stable(shutdown));

    assert_wiper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == 8'h00) && !(brownout && shutdown)) |=> $stable(wiper));

    assert_glitch_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brownout && shutdown) |=> wiper == 8'h80);

    assert_drive_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind dpot_i2c_regs dpot_i2c_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe_o),
    .sel      (bus_sel),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_ptr),
    .brownout (brownout_i),
    .shutdown (shutdown_o),
    .wiper    (wiper_o)
);

// File: tb/sim_dpot_i2c_regs.sv
`timescale 1ns/1ps
module sim_dpot_i2c_regs;
    localparam int       Q      = 8;
    localparam logic [4:0] DEV_HI = 5'b01011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       brownout = 1'b0;
    logic       sda_oe, shutdown;
    logic [7:0] wiper;
    logic       sda_line;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit mon_en = 0;
    bit oe_seen = 0;
    int oe_high_changes = 0;
    logic oe_prev = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    dpot_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .brownout_i(brownout),
        .wiper_o(wiper), .shutdown_o(shutdown)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (mon_en && sda_oe) oe_seen <= 1'b1;
        if (sda_oe != oe_prev && scl) oe_high_changes <= oe_high_changes + 1;
        oe_prev <= sda_oe;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1;   wait_clk(2*Q);
        sda_m = 1'b0; wait_clk(2*Q);
        scl = 1'b0;   wait_clk(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b1;   wait_clk(2*Q);
        sda_m = 1'b1; wait_clk(2*Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;  wait_clk(Q);
        scl = 1'b1; wait_clk(2*Q);
        scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        b = sda_line; wait_clk(Q);
        scl = 1'b0;   wait_clk(Q);
    endtask

    task automatic byte_out(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic byte_in(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(nack);
    endtask

    task automatic reg_wr(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                          output logic ok);
        logic a1, a2, a3;
        bus_start;
        byte_out({dev, 1'b0}, a1);
        byte_out(ra, a2);
        byte_out(d, a3);
        bus_stop;
        ok = a1 & a2 & a3;
    endtask

    task automatic reg_rd(input logic [6:0] dev, input logic [7:0] ra, output logic [7:0] d,
                          output logic ok);
        logic a1, a2, a3;
        bus_start;
        byte_out({dev, 1'b0}, a1);
        byte_out(ra, a2);
        bus_start;
        byte_out({dev, 1'b1}, a3);
        byte_in(d, 1'b1);
        bus_stop;
        ok = a1 & a2 & a3;
    endtask

    function automatic logic [6:0] dev_of(input logic [1:0] s);
        return {DEV_HI, s};
    endfunction

    task automatic t_reset;
        logic [7:0] d; logic ok;
        chk("R4 wiper_o after reset", wiper, 8'h80);
        chk("R4 shutdown_o after reset", {7'd0, shutdown}, 8'h00);
        chk("R4 sda_oe idle", {7'd0, sda_oe}, 8'h00);
        reg_rd(dev_of(strap), 8'h00, d, ok);
        chk("R1 address ack", {7'd0, ok}, 8'h01);
        chk("R4 wiper reads 80h", d, 8'h80);
        reg_rd(dev_of(strap), 8'h10, d, ok);
        chk("R4 ctrl reads 40h", d, 8'h40);
    endtask

    task automatic t_wiper_rw;
        logic [7:0] d; logic ok;
        logic [7:0] vals [3] = '{8'h5A, 8'h00, 8'hFF};
        foreach (vals[i]) begin
            reg_wr(dev_of(strap), 8'h00, vals[i], ok);
            chk("R3 write acked", {7'd0, ok}, 8'h01);
            chk("R3 wiper_o after write", wiper, vals[i]);
            reg_rd(dev_of(strap), 8'h00, d, ok);
            chk("R3 readback", d, vals[i]);
        end
    endtask

    task automatic t_mismatch;
        logic ok; logic [7:0] d;
        reg_wr(dev_of(strap), 8'h00, 8'h21, ok);
        oe_seen = 0; mon_en = 1;
        reg_wr(dev_of(strap ^ 2'b01), 8'h00, 8'hC3, ok);
        mon_en = 0;
        chk("R2 mismatch not acked", {7'd0, ok}, 8'h00);
        chk("R2 sda never driven", {7'd0, oe_seen}, 8'h00);
        chk("R2 wiper unchanged", wiper, 8'h21);
        reg_rd(dev_of(strap), 8'h00, d, ok);
        chk("R2 wiper readback unchanged", d, 8'h21);
    endtask

    task automatic t_strap;
        logic ok; logic [1:0] old;
        old = strap;
        strap = 2'b10; wait_clk(4);
        reg_wr(dev_of(2'b10), 8'h00, 8'h6C, ok);
        chk("R1 new strap acked", {7'd0, ok}, 8'h01);
        chk("R1 new strap write", wiper, 8'h6C);
        reg_wr(dev_of(old), 8'h00, 8'h01, ok);
        chk("R1 old strap not acked", {7'd0, ok}, 8'h00);
        chk("R1 old strap no write", wiper, 8'h6C);
        strap = old; wait_clk(4);
    endtask

    task automatic t_shutdown;
        logic ok; logic [7:0] d;
        reg_wr(dev_of(strap), 8'h00, 8'h47, ok);
        reg_wr(dev_of(strap), 8'h10, 8'h00, ok);
        chk("R5 shutdown entered", {7'd0, shutdown}, 8'h01);
        chk("R6 wiper kept in shutdown", wiper, 8'h47);
        reg_rd(dev_of(strap), 8'h10, d, ok);
        chk("R5 ctrl reads 00h", d, 8'h00);
        reg_wr(dev_of(strap), 8'h10, 8'h40, ok);
        chk("R5 shutdown left", {7'd0, shutdown}, 8'h00);
        chk("R6 wiper restored", wiper, 8'h47);
    endtask

    task automatic t_ctrl_bits;
        logic ok; logic [7:0] d;
        reg_wr(dev_of(strap), 8'h10, 8'hFF, ok);
        reg_rd(dev_of(strap), 8'h10, d, ok);
        chk("R5 only bit6 stored FFh", d, 8'h40);
        chk("R5 FFh keeps run", {7'd0, shutdown}, 8'h00);
        reg_wr(dev_of(strap), 8'h10, 8'hBF, ok);
        reg_rd(dev_of(strap), 8'h10, d, ok);
        chk("R5 only bit6 stored BFh", d, 8'h00);
        chk("R5 BFh enters shutdown", {7'd0, shutdown}, 8'h01);
        reg_wr(dev_of(strap), 8'h10, 8'h40, ok);
    endtask

    task automatic t_brownout;
        logic ok;
        reg_wr(dev_of(strap), 8'h00, 8'h33, ok);
        brownout = 1'b1; wait_clk(3); brownout = 1'b0; wait_clk(2);
        chk("R7 ignored when running", wiper, 8'h33);
        reg_wr(dev_of(strap), 8'h10, 8'h00, ok);
        chk("R7 wiper before glitch", wiper, 8'h33);
        brownout = 1'b1; wait_clk(1);
        chk("R7 mid-scale one clock later", wiper, 8'h80);
        brownout = 1'b0; wait_clk(2);
        reg_wr(dev_of(strap), 8'h10, 8'h40, ok);
        chk("R7 mid-scale kept on exit", wiper, 8'h80);
    endtask

    task automatic t_unimpl;
        logic ok; logic [7:0] d;
        reg_wr(dev_of(strap), 8'h00, 8'h9E, ok);
        reg_wr(dev_of(strap), 8'h05, 8'h77, ok);
        chk("R8 unimplemented write acked", {7'd0, ok}, 8'h01);
        chk("R8 wiper untouched", wiper, 8'h9E);
        chk("R8 shutdown untouched", {7'd0, shutdown}, 8'h00);
        reg_rd(dev_of(strap), 8'h05, d, ok);
        chk("R8 unimplemented read acked", {7'd0, ok}, 8'h01);
        chk("R8 unimplemented read 00h", d, 8'h00);
        reg_rd(dev_of(strap), 8'h01, d, ok);
        chk("R8 address 01h reads 00h", d, 8'h00);
    endtask

    task automatic t_burst;
        logic a1, a2, a3, a4, a5; logic [7:0] d; logic ok;
        bus_start;
        byte_out({dev_of(strap), 1'b0}, a1);
        byte_out(8'h00, a2);
        byte_out(8'h11, a3);
        byte_out(8'h22, a4);
        byte_out(8'h33, a5);
        bus_stop;
        chk("R9 extra bytes acked", {7'd0, a1 & a2 & a3 & a4 & a5}, 8'h01);
        chk("R9 last byte kept", wiper, 8'h33);
        reg_rd(dev_of(strap), 8'h00, d, ok);
        chk("R9 readback last byte", d, 8'h33);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset;
        t_wiper_rw;
        t_mismatch;
        t_strap;
        t_shutdown;
        t_ctrl_bits;
        t_brownout;
        t_unimpl;
        t_burst;
        chk("R10 sda drive changes while SCL high", oe_high_changes[7:0], 8'h00);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule